// File: doc/BRIEF.md
# Processor Exception Entry Arbiter

This block decides in which cycle a small processor core enters an exception, and which one. Two active-low interrupt request lines, a fast one and a normal one, are treated as level-sensitive. Each passes through a two-stage synchronizer before arbitration sees it. An external abort line is looked at only when the core marks the end of a memory cycle. The core also says whether that cycle was an instruction fetch or a data access, and this splits the abort into a prefetch abort or a data abort.

The arbiter holds the two interrupt mask bits of the status register. When an exception is chosen it gives a one-cycle, one-hot taken pulse, a 3-bit vector code and the link value to save in the return register, and it updates the masks. No further exception is chosen until the core acknowledges entry. Interrupts and prefetch aborts are taken only on an instruction boundary that the core signals. A data abort does not wait for one.

Top module: `exc_entry_arb`

## Requirements
- R1: After reset, `exc_take` is 0, both `i_mask` and `f_mask` are 1, and no abort is pending.
- R2: A low level on a request line reaches arbitration through a two-stage synchronizer. If the line is first low at rising edge k and stays low, the taken pulse is visible after edge k+2 at the earliest. A line held high never causes entry.
- R3: A fast interrupt, a normal interrupt or a prefetch abort is selected only in a cycle where `insn_boundary` is 1.
- R4: The selection priority is data abort first, then fast interrupt, then prefetch abort, then normal interrupt.
- R5: Every entry sets `i_mask`. Fast-interrupt entry also sets `f_mask`. Other entries leave `f_mask` unchanged.
- R6: `i_mask`=1 blocks the normal interrupt, and `f_mask`=1 blocks the fast interrupt. Aborts cannot be masked.
- R7: `mask_wr` loads `mask_wdata[1]` into `i_mask` and `mask_wdata[0]` into `f_mask`, but only when `mask_priv` is 1. The write is discarded in a cycle where an exception is selected.
- R8: `mem_abort` is sampled only when `mem_cyc_end` is 1. With `mem_is_fetch`=1 it records a pending prefetch abort, and with 0 a pending data abort. At other times it has no effect.
- R9: A pending data abort is selected in the next free cycle, whatever the value of `insn_boundary`.
- R10: The link value is `exec_pc`+8 for a data abort and `exec_pc`+4 for the other three. `exec_pc` is sampled in the selection cycle.
- R11: `exc_take` is a one-hot pulse one cycle long. Bit 0 is data abort, bit 1 fast interrupt, bit 2 prefetch abort and bit 3 normal interrupt. `exc_vec` is 3'b100, 3'b111, 3'b011 or 3'b110 respectively. `exc_vec` and `exc_link` are held until the next entry.
- R12: After an entry, no other exception is selected until a cycle with `exc_ack`=1. It may be selected in the cycle after that one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fiq_req_n | input | 1 | Fast interrupt request, active low, asynchronous |
| irq_req_n | input | 1 | Normal interrupt request, active low, asynchronous |
| insn_boundary | input | 1 | Core is between instructions |
| exec_pc | input | AW | Address of the instruction in execute |
| mem_cyc_end | input | 1 | Last cycle of a memory access |
| mem_is_fetch | input | 1 | 1 = that access is an instruction fetch, 0 = data |
| mem_abort | input | 1 | Abort response for the access |
| mask_wr | input | 1 | Write strobe for the mask bits |
| mask_priv | input | 1 | Core is in a privileged mode |
| mask_wdata | input | 2 | [1] = normal mask, [0] = fast mask |
| exc_ack | input | 1 | Core has completed exception entry |
| exc_take | output | 4 | One-hot taken pulse |
| exc_vec | output | 3 | Vector code of the last entry |
| exc_link | output | AW | Link value of the last entry |
| i_mask | output | 1 | Normal interrupt mask |
| f_mask | output | 1 | Fast interrupt mask |

## Verification
A software mask write can land in the same cycle as the entry that also updates the masks. The bench provokes this by timing a privileged write that clears both masks to the cycle after a normal request clears the synchronizer. It then expects `i_mask` to read 1 after the pulse. A second collision is a data abort and a fast interrupt that are pending together. Here the bench holds acknowledge high and expects the data abort pulse first and the fast interrupt pulse after it. A behavioural model in the bench compares every output on every clock.

// File: rtl/exc_arb_pkg.sv
package exc_arb_pkg;

  typedef enum logic [1:0] {
    EXK_DABT = 2'd0,
    EXK_FIQ  = 2'd1,
    EXK_PABT = 2'd2,
    EXK_IRQ  = 2'd3
  } exc_kind_t;

  localparam int unsigned EXC_KINDS = 4;
  localparam int unsigned VEC_W     = 3;

  function automatic logic [VEC_W-1:0] vec_code(exc_kind_t k);
    case (k)
      EXK_DABT: return 3'b100;
      EXK_FIQ:  return 3'b111;
      EXK_PABT: return 3'b011;
      default:  return 3'b110;
    endcase
  endfunction

  function automatic int unsigned link_adj(exc_kind_t k);
    return (k == EXK_DABT) ? 8 : 4;
  endfunction

endpackage

// File: rtl/exc_sync.sv
module exc_sync #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [LANES-1:0] IDLE = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] d_in,
  output logic [LANES-1:0] d_out
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb chain_d = {chain_q[STAGES-2:0], d_in[g]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{IDLE[g]}};
      else        chain_q <= chain_d;
    end

    assign d_out[g] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/exc_select.sv
module exc_select
  import exc_arb_pkg::*;
(
  input  logic      busy,
  input  logic      boundary,
  input  logic      dabt_pend,
  input  logic      fiq_live,
  input  logic      pabt_pend,
  input  logic      irq_live,
  output logic      sel_vld,
  output exc_kind_t sel_kind
);

  always_comb begin
    sel_vld  = 1'b0;
    sel_kind = EXK_IRQ;
    if (!busy) begin
      if (dabt_pend) begin
        sel_vld  = 1'b1;
        sel_kind = EXK_DABT;
      end else if (boundary) begin
        if (fiq_live) begin
          sel_vld  = 1'b1;
          sel_kind = EXK_FIQ;
        end else if (pabt_pend) begin
          sel_vld  = 1'b1;
          sel_kind = EXK_PABT;
        end else if (irq_live) begin
          sel_vld  = 1'b1;
          sel_kind = EXK_IRQ;
        end
      end
    end
  end

endmodule

// File: rtl/exc_mask_reg.sv
module exc_mask_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic priv,
  input  logic wr_i,
  input  logic wr_f,
  input  logic entry,
  input  logic entry_fiq,
  output logic i_mask,
  output logic f_mask
);

  logic i_q, f_q, i_d, f_d;

  always_comb begin
    i_d = i_q;
    f_d = f_q;
    if (entry) begin
      i_d = 1'b1;
      if (entry_fiq) f_d = 1'b1;
    end else if (wr_en && priv) begin
      i_d = wr_i;
      f_d = wr_f;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_q <= 1'b1;
      f_q <= 1'b1;
    end else begin
      i_q <= i_d;
      f_q <= f_d;
    end
  end

  assign i_mask = i_q;
  assign f_mask = f_q;

  // R7
  unpriv_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !priv && !entry) |=> $stable({i_q, f_q}));

  // R5
  entry_imask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry |=> i_q);

endmodule

// File: rtl/exc_entry_arb.sv
module exc_entry_arb
  import exc_arb_pkg::*;
#(
  parameter int unsigned AW          = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fiq_req_n,
  input  logic                 irq_req_n,
  input  logic                 insn_boundary,
  input  logic [AW-1:0]        exec_pc,
  input  logic                 mem_cyc_end,
  input  logic                 mem_is_fetch,
  input  logic                 mem_abort,
  input  logic                 mask_wr,
  input  logic                 mask_priv,
  input  logic [1:0]           mask_wdata,
  input  logic                 exc_ack,
  output logic [EXC_KINDS-1:0] exc_take,
  output logic [VEC_W-1:0]     exc_vec,
  output logic [AW-1:0]        exc_link,
  output logic                 i_mask,
  output logic                 f_mask
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int_n = rst_q[1];

  // request synchronizers
  logic fiq_n_s, irq_n_s;

  exc_sync #(.LANES(2), .STAGES(SYNC_STAGES), .IDLE(2'b11)) i_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_in  ({fiq_req_n, irq_req_n}),
    .d_out ({fiq_n_s, irq_n_s})
  );

  logic fiq_live, irq_live;
  assign fiq_live = !fiq_n_s && !f_mask;
  assign irq_live = !irq_n_s && !i_mask;

  // abort capture and hold-off state
  logic pabt_q, pabt_d, dabt_q, dabt_d, busy_q, busy_d;
  logic abt_fetch, abt_data;
  logic      sel_vld;
  exc_kind_t sel_kind;

  assign abt_fetch = mem_cyc_end && mem_abort &&  mem_is_fetch;
  assign abt_data  = mem_cyc_end && mem_abort && !mem_is_fetch;

  always_comb begin
    pabt_d = (pabt_q && !(sel_vld && sel_kind == EXK_PABT)) || abt_fetch;
    dabt_d = (dabt_q && !(sel_vld && sel_kind == EXK_DABT)) || abt_data;
    busy_d = busy_q;
    if (sel_vld)      busy_d = 1'b1;
    else if (exc_ack) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pabt_q <= 1'b0;
      dabt_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      pabt_q <= pabt_d;
      dabt_q <= dabt_d;
      busy_q <= busy_d;
    end
  end

  exc_select i_select (
    .busy      (busy_q),
    .boundary  (insn_boundary),
    .dabt_pend (dabt_q),
    .fiq_live  (fiq_live),
    .pabt_pend (pabt_q),
    .irq_live  (irq_live),
    .sel_vld   (sel_vld),
    .sel_kind  (sel_kind)
  );

  exc_mask_reg i_mask_reg (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (mask_wr),
    .priv      (mask_priv),
    .wr_i      (mask_wdata[1]),
    .wr_f      (mask_wdata[0]),
    .entry     (sel_vld),
    .entry_fiq (sel_kind == EXK_FIQ),
    .i_mask    (i_mask),
    .f_mask    (f_mask)
  );

  // entry outputs
  logic [EXC_KINDS-1:0] take_q, take_d;
  logic [VEC_W-1:0]     vec_q, vec_d;
  logic [AW-1:0]        link_q, link_d;
  logic                 info_en;

  always_comb begin
    take_d  = sel_vld ? (EXC_KINDS'(1) << sel_kind) : '0;
    info_en = sel_vld;
    vec_d   = vec_code(sel_kind);
    link_d  = exec_pc + AW'(link_adj(sel_kind));
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      take_q <= '0;
      vec_q  <= '0;
      link_q <= '0;
    end else begin
      take_q <= take_d;
      if (info_en) begin
        vec_q  <= vec_d;
        link_q <= link_d;
      end
    end
  end

  assign exc_take = take_q;
  assign exc_vec  = vec_q;
  assign exc_link = link_q;

  // R11
  take_pulse_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (|exc_take) |=> (exc_take == '0));

  // R11
  take_onehot_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(exc_take));

  // R12
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    busy_q |=> (exc_take == '0));

  // R10
  dabt_link_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    exc_take[0] |-> (exc_link == $past(exec_pc) + AW'(8)));

  // R5
  fiq_mask_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    exc_take[1] |-> (f_mask && i_mask));

  // R9
  dabt_entry_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (abt_data && !busy_q && !sel_vld) |=> ##1 exc_take[0]);

endmodule

// File: tb/test_exc_entry_arb.sv
module test_exc_entry_arb;

  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fiq_req_n = 1'b1, irq_req_n = 1'b1, insn_boundary = 1'b0;
  logic [AW-1:0] exec_pc = '0;
  logic mem_cyc_end = 1'b0, mem_is_fetch = 1'b0, mem_abort = 1'b0;
  logic mask_wr = 1'b0, mask_priv = 1'b0;
  logic [1:0] mask_wdata = 2'b00;
  logic exc_ack = 1'b0;
  logic [3:0] exc_take;
  logic [2:0] exc_vec;
  logic [AW-1:0] exc_link;
  logic i_mask, f_mask;

  always #4 clk = ~clk;

  exc_entry_arb #(.AW(AW)) i_exc_entry_arb (
    .clk(clk), .rst_n(rst_n), .fiq_req_n(fiq_req_n), .irq_req_n(irq_req_n),
    .insn_boundary(insn_boundary), .exec_pc(exec_pc), .mem_cyc_end(mem_cyc_end),
    .mem_is_fetch(mem_is_fetch), .mem_abort(mem_abort), .mask_wr(mask_wr),
    .mask_priv(mask_priv), .mask_wdata(mask_wdata), .exc_ack(exc_ack),
    .exc_take(exc_take), .exc_vec(exc_vec), .exc_link(exc_link),
    .i_mask(i_mask), .f_mask(f_mask)
  );

  int total = 0;
  int bad = 0;
  string cur_req = "R1";
  bit comparing = 1'b0;
  int takes_seen = 0;

  // behavioural reference model
  bit fq[$];
  bit iq[$];
  bit m_dp, m_pp, m_busy, m_im, m_fm;
  int m_take;
  int m_vec;
  longint m_link;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fq = '{1'b1, 1'b1};
      iq = '{1'b1, 1'b1};
      m_dp = 0; m_pp = 0; m_busy = 0; m_im = 1; m_fm = 1;
      m_take = 0; m_vec = 0; m_link = 0;
    end else begin
      int sel;
      bit fs, is;
      fs = fq[0];
      is = iq[0];
      sel = -1;
      if (!m_busy) begin
        if (m_dp) sel = 0;
        else if (insn_boundary) begin
          if (!fs && !m_fm)       sel = 1;
          else if (m_pp)          sel = 2;
          else if (!is && !m_im)  sel = 3;
        end
      end
      m_take = (sel >= 0) ? (1 << sel) : 0;
      if (sel >= 0) begin
        case (sel)
          0: m_vec = 4; 1: m_vec = 7; 2: m_vec = 3; default: m_vec = 6;
        endcase
        m_link = (longint'(exec_pc) + ((sel == 0) ? 8 : 4)) & 64'hFFFF_FFFF;
        m_im = 1;
        if (sel == 1) m_fm = 1;
        m_busy = 1;
      end else begin
        if (mask_wr && mask_priv) begin
          m_im = mask_wdata[1];
          m_fm = mask_wdata[0];
        end
        if (exc_ack) m_busy = 0;
      end
      m_dp = (m_dp && sel != 0) || (mem_cyc_end && mem_abort && !mem_is_fetch);
      m_pp = (m_pp && sel != 2) || (mem_cyc_end && mem_abort && mem_is_fetch);
      void'(fq.pop_front()); fq.push_back(fiq_req_n);
      void'(iq.pop_front()); iq.push_back(irq_req_n);
    end
  end

  task automatic chk(string tag, longint act, longint exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (comparing) begin
      chk(cur_req, exc_take, m_take, "exc_take");
      chk(cur_req, {i_mask, f_mask}, {m_im, m_fm}, "masks");
      if (m_take != 0) begin
        takes_seen++;
        chk(cur_req, exc_vec, m_vec, "exc_vec");
        chk(cur_req, exc_link, m_link, "exc_link");
      end
    end
  end

  task automatic tick(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic priv_write(logic [1:0] d);
    mask_wr = 1; mask_priv = 1; mask_wdata = d;
    tick(1);
    mask_wr = 0; mask_priv = 0;
    tick(1);
  endtask

  task automatic ack_once();
    exc_ack = 1; tick(1); exc_ack = 0; tick(1);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", wd);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(4);
    comparing = 1;
    // R1 reset state
    chk("R1", exc_take, 0, "take after reset");
    chk("R1", {i_mask, f_mask}, 2'b11, "masks after reset");

    // R7 unprivileged write ignored
    cur_req = "R7";
    mask_wr = 1; mask_priv = 0; mask_wdata = 2'b00;
    tick(1); mask_wr = 0; tick(1);
    chk("R7", {i_mask, f_mask}, 2'b11, "masks after unpriv write");
    priv_write(2'b00);
    chk("R7", {i_mask, f_mask}, 2'b00, "masks after priv write");

    // R3 no boundary, no entry
    cur_req = "R3";
    irq_req_n = 0; exec_pc = 32'h100;
    tick(6);
    // R2 entry through synchronizer
    cur_req = "R2";
    insn_boundary = 1;
    tick(2);
    chk("R2", takes_seen, 1, "normal interrupt taken");
    chk("R11", exc_vec, 3'b110, "normal interrupt vector");
    irq_req_n = 1; insn_boundary = 0;
    // R12 hold without ack
    cur_req = "R12";
    fiq_req_n = 0; insn_boundary = 1;
    tick(5);
    chk("R12", takes_seen, 1, "no entry while unacknowledged");
    fiq_req_n = 1; insn_boundary = 0;
    tick(3);
    ack_once();

    // R6 masked normal interrupt
    cur_req = "R6";
    irq_req_n = 0; insn_boundary = 1;
    tick(6);
    irq_req_n = 1; insn_boundary = 0;
    tick(3);
    priv_write(2'b00);

    // R4 fast beats normal, R5 masks
    cur_req = "R4";
    fiq_req_n = 0; irq_req_n = 0; insn_boundary = 1; exec_pc = 32'h140;
    tick(5);
    fiq_req_n = 1; irq_req_n = 1; insn_boundary = 0;
    cur_req = "R5";
    tick(3);
    chk("R5", {i_mask, f_mask}, 2'b11, "masks after fast entry");
    ack_once();
    cur_req = "R6";
    fiq_req_n = 0; insn_boundary = 1;
    tick(5);
    fiq_req_n = 1; insn_boundary = 0;
    tick(3);
    priv_write(2'b00);

    // R8 abort outside memory-cycle end ignored
    cur_req = "R8";
    mem_abort = 1; mem_is_fetch = 0; insn_boundary = 1;
    tick(4);
    mem_abort = 0; insn_boundary = 0;
    tick(2);

    // R9 data abort, no boundary; R10 link
    cur_req = "R9";
    exec_pc = 32'h200;
    mem_cyc_end = 1; mem_abort = 1; mem_is_fetch = 0;
    tick(1);
    mem_cyc_end = 0; mem_abort = 0;
    cur_req = "R10";
    tick(3);
    chk("R10", exc_link, 32'h208, "data abort link");
    ack_once();

    // prefetch abort waits for boundary
    cur_req = "R3";
    mem_cyc_end = 1; mem_abort = 1; mem_is_fetch = 1;
    tick(1);
    mem_cyc_end = 0; mem_abort = 0; mem_is_fetch = 0;
    tick(4);
    cur_req = "R10";
    insn_boundary = 1; exec_pc = 32'h300;
    tick(2);
    insn_boundary = 0;
    chk("R10", exc_link, 32'h304, "prefetch abort link");
    ack_once();

    // R4 data abort vs fast interrupt, ack held high
    priv_write(2'b00);
    cur_req = "R4";
    fiq_req_n = 0; insn_boundary = 1; exec_pc = 32'h400;
    mem_cyc_end = 1; mem_abort = 1;
    tick(1);
    mem_cyc_end = 0; mem_abort = 0;
    exc_ack = 1;
    tick(8);
    exc_ack = 0; fiq_req_n = 1; insn_boundary = 0;
    tick(3);
    ack_once();

    // R7 write collides with entry
    priv_write(2'b00);
    cur_req = "R7";
    irq_req_n = 0; insn_boundary = 1;
    tick(2);
    mask_wr = 1; mask_priv = 1; mask_wdata = 2'b00;
    tick(1);
    mask_wr = 0; mask_priv = 0; irq_req_n = 1; insn_boundary = 0;
    tick(1);
    chk("R7", i_mask, 1, "entry overrides mask write");
    ack_once();
    cur_req = "R11";
    tick(3);
    chk("R11", takes_seen, 7, "number of entries");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule